// File: doc/BRIEF.md
# Relative Branch Condition Unit

This block decides whether a short PC-relative branch or a bit-test jump is taken, and produces the program counter that follows it. The address space is 24 bits and word aligned. A branch carries a signed 8-bit displacement that counts 16-bit words, so it is doubled before it is added to the current PC. The sum wraps at 24 bits and bit 0 is forced low. A branch that is not taken continues at the sequential PC. The fetch stage computes that value and supplies it as an input.

Each request supplies a branch-kind selector, the four status flags (carry, zero, negative, overflow) and, for bit-test jumps, the value of the tested bit. The block also forms a 10-bit bit address from two low opcode bits and the following byte. It drives that address combinationally, so the surrounding pipeline can fetch the bit in the same cycle. The decision and the next PC are registered and appear one clock after the request.

Top module: `rel_branch_unit`

## Requirements
- R1: While reset is asserted, and after it is released with no request yet made, `out_valid` and `out_taken` are 0 and `out_pc` is 0.
- R2: A request with `in_valid`=1 sampled at a rising edge shows up on `out_valid`=1 after that same edge. If `in_valid`=0 at an edge, `out_valid` and `out_taken` are 0 after that edge.
- R3: When taken, `out_pc` = (`in_pc` + 2 × sign-extended `in_disp`) AND 0xFFFFFE. The sum wraps modulo 2^24 in both directions, and bit 0 of `out_pc` is always 0.
- R4: When not taken, `out_pc` equals the `in_seq_pc` of the request, unchanged.
- R5: Carry and zero kinds: code 1 is taken when C=0, code 2 when C=1, code 3 when Z=1, and code 4 when Z=0.
- R6: Sign and overflow kinds: code 5 is taken when N=1, code 6 when N=0, code 7 when V=1, and code 8 when V=0.
- R7: Code 0 (unconditional) is always taken. Codes 17 to 31 are never taken, whatever the flags and the bit.
- R8: Unsigned compares: code 9 is taken when (C or Z)=0, and code 10 when (C or Z)=1.
- R9: Signed compares: code 11 is taken when (N xor V)=0, code 12 when (N xor V)=1, code 13 when (Z or (N xor V))=0, and code 14 when (Z or (N xor V))=1.
- R10: Bit tests: code 15 is taken when `bit_val`=1 and code 16 when `bit_val`=0. `bit_addr` equals {`bit_sel_hi`, `bit_sel_lo`} combinationally.
- R11: Only code 15 and code 16 depend on `bit_val`. No other code's decision changes with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A branch request is present this cycle |
| in_kind | input | 5 | Branch-kind code (see R5 to R10) |
| in_pc | input | 24 | PC that the displacement is added to |
| in_seq_pc | input | 24 | Fall-through PC used when not taken |
| in_disp | input | 8 | Signed displacement in words |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| bit_sel_hi | input | 2 | Low opcode bits, upper part of the bit address |
| bit_sel_lo | input | 8 | Operand byte, lower part of the bit address |
| bit_val | input | 1 | Value of the addressed bit |
| bit_addr | output | 10 | Bit address for the memory lookup |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_taken | output | 1 | Branch decision |
| out_pc | output | 24 | Next program counter |

## Verification
The bench runs every code from 0 to 31 against all sixteen flag combinations and both bit values. A swapped polarity, a wrong signed or unsigned formula, a code that leaks into the undefined range, or a non-bit kind that listens to `bit_val` each gives a wrong decision for some combination. Displacements of 0x7F, 0x80 and 0xFF are applied at PCs near 0 and near 0xFFFFFF. A design that skips the doubling, zero-extends the byte, fails to wrap, or leaves bit 0 set lands on a different target. Requests separated by idle cycles show whether the valid and taken bits are cleared, and whether a not-taken result passes the sequential PC through without aligning it.

// File: rtl/rbu_pkg.sv
package rbu_pkg;

    localparam int PC_W      = 24;
    localparam int DISP_W    = 8;
    localparam int KIND_W    = 5;
    localparam int BSEL_HI_W = 2;
    localparam int BSEL_LO_W = 8;
    localparam int BITA_W    = BSEL_HI_W + BSEL_LO_W;

    typedef enum logic [KIND_W-1:0] {
        BK_ALWAYS  = 5'd0,
        BK_C_CLR   = 5'd1,
        BK_C_SET   = 5'd2,
        BK_EQ      = 5'd3,
        BK_NE      = 5'd4,
        BK_MINUS   = 5'd5,
        BK_PLUS    = 5'd6,
        BK_OVF     = 5'd7,
        BK_NOVF    = 5'd8,
        BK_UGT     = 5'd9,
        BK_ULE     = 5'd10,
        BK_SGE     = 5'd11,
        BK_SLT     = 5'd12,
        BK_SGT     = 5'd13,
        BK_SLE     = 5'd14,
        BK_BIT_SET = 5'd15,
        BK_BIT_CLR = 5'd16
    } br_kind_e;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
    } flags_t;

    typedef struct packed {
        logic            valid;
        logic            taken;
        logic [PC_W-1:0] pc;
    } br_result_t;

endpackage

// File: rtl/rbu_cond_eval.sv
module rbu_cond_eval
    import rbu_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    input  flags_t            flags,
    input  logic              bit_val,
    output logic              taken
);
    logic signed_lt;
    logic unsigned_le;

    always_comb begin
        signed_lt   = flags.n ^ flags.v;
        unsigned_le = flags.c | flags.z;
        taken       = 1'b0;
        case (kind)
            BK_ALWAYS:  taken = 1'b1;
            BK_C_CLR:   taken = ~flags.c;
            BK_C_SET:   taken = flags.c;
            BK_EQ:      taken = flags.z;
            BK_NE:      taken = ~flags.z;
            BK_MINUS:   taken = flags.n;
            BK_PLUS:    taken = ~flags.n;
            BK_OVF:     taken = flags.v;
            BK_NOVF:    taken = ~flags.v;
            BK_UGT:     taken = ~unsigned_le;
            BK_ULE:     taken = unsigned_le;
            BK_SGE:     taken = ~signed_lt;
            BK_SLT:     taken = signed_lt;
            BK_SGT:     taken = ~(flags.z | signed_lt);
            BK_SLE:     taken = flags.z | signed_lt;
            BK_BIT_SET: taken = bit_val;
            BK_BIT_CLR: taken = ~bit_val;
            default:    taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/rbu_target_calc.sv
module rbu_target_calc
    import rbu_pkg::*;
(
    input  logic [PC_W-1:0]   pc,
    input  logic [DISP_W-1:0] disp,
    output logic [PC_W-1:0]   target
);
    localparam int EXT_W = PC_W - DISP_W - 1;

    logic [PC_W-1:0] offset;
    logic [PC_W-1:0] sum;

    always_comb begin
        // sign-extend and scale words to bytes
        offset = {{EXT_W{disp[DISP_W-1]}}, disp, 1'b0};
        sum    = pc + offset;
        target = {sum[PC_W-1:1], 1'b0};
    end
endmodule

// File: rtl/rbu_bitaddr.sv
module rbu_bitaddr
    import rbu_pkg::*;
(
    input  logic [BSEL_HI_W-1:0] sel_hi,
    input  logic [BSEL_LO_W-1:0] sel_lo,
    output logic [BITA_W-1:0]    addr
);
    always_comb begin
        addr = {sel_hi, sel_lo};
    end
endmodule

// File: rtl/rel_branch_unit.sv
module rel_branch_unit
    import rbu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [KIND_W-1:0]    in_kind,
    input  logic [PC_W-1:0]      in_pc,
    input  logic [PC_W-1:0]      in_seq_pc,
    input  logic [DISP_W-1:0]    in_disp,
    input  logic                 flag_c,
    input  logic                 flag_z,
    input  logic                 flag_n,
    input  logic                 flag_v,
    input  logic [BSEL_HI_W-1:0] bit_sel_hi,
    input  logic [BSEL_LO_W-1:0] bit_sel_lo,
    input  logic                 bit_val,
    output logic [BITA_W-1:0]    bit_addr,
    output logic                 out_valid,
    output logic                 out_taken,
    output logic [PC_W-1:0]      out_pc
);
    flags_t          flags;
    logic            cond_taken;
    logic [PC_W-1:0] target_pc;
    br_result_t      res_d, res_q;

    assign flags = '{c: flag_c, z: flag_z, n: flag_n, v: flag_v};

    rbu_cond_eval u_cond (
        .kind    (in_kind),
        .flags   (flags),
        .bit_val (bit_val),
        .taken   (cond_taken)
    );

    rbu_target_calc u_target (
        .pc     (in_pc),
        .disp   (in_disp),
        .target (target_pc)
    );

    rbu_bitaddr u_bitaddr (
        .sel_hi (bit_sel_hi),
        .sel_lo (bit_sel_lo),
        .addr   (bit_addr)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        res_d.taken = in_valid & cond_taken;
        if (in_valid) begin
            res_d.pc = cond_taken ? target_pc : in_seq_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign out_taken = res_q.taken;
    assign out_pc    = res_q.pc;

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_taken));

    // R3
    target_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_taken) |-> (out_pc[0] == 1'b0));

    // R4
    seq_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cond_taken) |=> (out_pc == $past(in_seq_pc)));

    // R7
    always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == BK_ALWAYS) |=> out_taken);

    // R7
    undef_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind > BK_BIT_CLR) |=> !out_taken);
endmodule

// File: tb/rel_branch_unit_test.sv
module rel_branch_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [4:0]  in_kind;
    logic [23:0] in_pc;
    logic [23:0] in_seq_pc;
    logic [7:0]  in_disp;
    logic        flag_c, flag_z, flag_n, flag_v;
    logic [1:0]  bit_sel_hi;
    logic [7:0]  bit_sel_lo;
    logic        bit_val;
    logic [9:0]  bit_addr;
    logic        out_valid;
    logic        out_taken;
    logic [23:0] out_pc;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rel_branch_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
        .in_pc(in_pc), .in_seq_pc(in_seq_pc), .in_disp(in_disp),
        .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v),
        .bit_sel_hi(bit_sel_hi), .bit_sel_lo(bit_sel_lo), .bit_val(bit_val),
        .bit_addr(bit_addr), .out_valid(out_valid), .out_taken(out_taken),
        .out_pc(out_pc)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // decision expected from the requirement table
    function automatic bit ref_taken(int k, bit c, bit z, bit n, bit v, bit b);
        bit lt = (n != v);
        if (k == 0)  return 1;
        if (k == 1)  return !c;
        if (k == 2)  return c;
        if (k == 3)  return z;
        if (k == 4)  return !z;
        if (k == 5)  return n;
        if (k == 6)  return !n;
        if (k == 7)  return v;
        if (k == 8)  return !v;
        if (k == 9)  return !(c || z);
        if (k == 10) return c || z;
        if (k == 11) return !lt;
        if (k == 12) return lt;
        if (k == 13) return !(z || lt);
        if (k == 14) return z || lt;
        if (k == 15) return b;
        if (k == 16) return !b;
        return 0;
    endfunction

    function automatic string req_of(int k);
        if (k == 0 || k > 16) return "R7";
        if (k <= 4)  return "R5";
        if (k <= 8)  return "R6";
        if (k <= 10) return "R8";
        if (k <= 14) return "R9";
        return "R10";
    endfunction

    function automatic logic [23:0] ref_target(logic [23:0] pc, logic [7:0] d);
        int signed s = $signed(d);
        int signed t = int'(pc) + 2 * s;
        logic [31:0] u = t;
        return u[23:0] & 24'hFFFFFE;
    endfunction

    task automatic drive(int k, logic [23:0] pc, logic [23:0] seq, logic [7:0] d,
                         logic [3:0] f, bit b);
        @(negedge clk);
        in_valid  = 1'b1;
        in_kind   = k[4:0];
        in_pc     = pc;
        in_seq_pc = seq;
        in_disp   = d;
        {flag_c, flag_z, flag_n, flag_v} = f;
        bit_val   = b;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        in_valid = 1'b0; in_kind = '0; in_pc = '0; in_seq_pc = '0; in_disp = '0;
        {flag_c, flag_z, flag_n, flag_v} = '0;
        bit_sel_hi = '0; bit_sel_lo = '0; bit_val = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", 32'(out_valid), 0);
        check("R1", "taken in reset", 32'(out_taken), 0);
        check("R1", "pc in reset", 32'(out_pc), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "valid after reset", 32'(out_valid), 0);
        check("R1", "pc after reset", 32'(out_pc), 0);
    endtask

    // every kind, all flag patterns, both bit values (R5 R6 R7 R8 R9 R10 R11)
    task automatic t_all_kinds();
        for (int k = 0; k < 32; k++) begin
            for (int f = 0; f < 16; f++) begin
                for (int b = 0; b < 2; b++) begin
                    logic [23:0] pc  = 24'h001000 + 24'(k * 64);
                    logic [23:0] seq = pc + 24'd2;
                    logic [7:0]  d   = 8'(k * 7 + f);
                    bit exp_t = ref_taken(k, f[3], f[2], f[1], f[0], b[0]);
                    drive(k, pc, seq, d, f[3:0], b[0]);
                    check("R2", "valid", 32'(out_valid), 1);
                    check(req_of(k), $sformatf("taken k=%0d f=%0h b=%0d", k, f, b),
                          32'(out_taken), 32'(exp_t));
                    check(exp_t ? "R3" : "R4", "next pc", 32'(out_pc),
                          32'(exp_t ? ref_target(pc, d) : seq));
                end
            end
        end
    endtask

    // R11: decisions of non-bit kinds do not depend on bit_val
    task automatic t_bit_ignored();
        for (int k = 0; k < 15; k++) begin
            drive(k, 24'h000400, 24'h000402, 8'h05, 4'b0101, 1'b0);
            begin
                logic t0 = out_taken;
                drive(k, 24'h000400, 24'h000402, 8'h05, 4'b0101, 1'b1);
                check("R11", $sformatf("bit ignored k=%0d", k), 32'(out_taken), 32'(t0));
            end
        end
    endtask

    task automatic t_target_edges();
        drive(0, 24'h000100, 24'h000102, 8'h7F, 4'h0, 0);
        check("R3", "max forward", 32'(out_pc), 32'h0001FE);
        drive(0, 24'h000100, 24'h000102, 8'h80, 4'h0, 0);
        check("R3", "max backward", 32'(out_pc), 32'h000000);
        drive(0, 24'h000010, 24'h000012, 8'hFF, 4'h0, 0);
        check("R3", "minus one word", 32'(out_pc), 32'h00000E);
        drive(0, 24'hFFFFFE, 24'h000000, 8'h02, 4'h0, 0);
        check("R3", "wrap upward", 32'(out_pc), 32'h000002);
        drive(0, 24'h000002, 24'h000004, 8'hFE, 4'h0, 0);
        check("R3", "wrap downward", 32'(out_pc), 32'hFFFFFE);
        drive(0, 24'h123457, 24'h123459, 8'h00, 4'h0, 0);
        check("R3", "odd pc cleared", 32'(out_pc), 32'h123456);
        drive(2, 24'h000200, 24'h000203, 8'h10, 4'h0, 0);
        check("R4", "odd seq pc kept", 32'(out_pc), 32'h000203);
    endtask

    task automatic t_idle();
        drive(0, 24'h000050, 24'h000052, 8'h01, 4'h0, 0);
        check("R2", "taken before idle", 32'(out_taken), 1);
        @(negedge clk);
        check("R2", "idle valid", 32'(out_valid), 0);
        check("R2", "idle taken", 32'(out_taken), 0);
    endtask

    task automatic t_bitaddr();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            bit_sel_hi = 2'(i);
            bit_sel_lo = 8'(8'hA5 ^ (i * 8'h33));
            #1;
            check("R10", "bit address", 32'(bit_addr), 32'({bit_sel_hi, bit_sel_lo}));
        end
        bit_sel_hi = 2'b11; bit_sel_lo = 8'hFF; #1;
        check("R10", "bit address max", 32'(bit_addr), 32'h3FF);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_all_kinds();
        t_bit_ignored();
        t_target_edges();
        t_idle();
        t_bitaddr();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule